// File: doc/BRIEF.md
# Multi-format serial audio transmitter

The block takes pairs of parallel audio samples (one left, one right) through a ready/valid handshake and sends them most significant bit first on one serial data line. A bit clock times each bit, and a frame clock shows which channel is on the line. Four framings can be chosen while the block runs: left justified, I2S, right justified and DSP. The word length is set from 16 to 32 bits. The number of bit clocks in each channel slot is set separately.

In master mode the block makes the bit clock by dividing the system clock by a whole number, and it makes the frame clock itself. In slave mode it follows a bit clock and a frame clock from outside. Both are brought into the system clock domain through two-flop synchronizers, and the block then acts on the detected falling edges of the bit clock. A one-entry holding register decouples the handshake from the frame timing. If no new pair is waiting when a frame begins, the last pair is sent again and an underrun is reported.

Top module: `aud_ser_tx`

## Requirements
- R1: Each word is sent most significant bit first. The sample occupies bits `cfg_wlen-1..0` of `s_left`/`s_right`, and the upper bits are ignored. `cfg_wlen` holds the word length in bits.
- R2: `cfg_err` goes high one clock after any of these holds: `cfg_fmt`=2 (right justified) with `cfg_wlen`=32; `cfg_wlen` below 16 or above 32; `cfg_slots` below `cfg_wlen`. While it is high, `sdata` stays 0.
- R3: In formats 0, 1 and 2, `lrck_o` is 0 during the left slot and 1 during the right slot. Each frame sends the left word first.
- R4: `sdata` and `lrck_o` change only at falling bit-clock edges. In master mode this is the same system clock edge on which `bclk_o` falls.
- R5: Left justified (`cfg_fmt`=0): the MSB occupies bit slot 0 of its channel, so it is valid at the first rising edge after the frame clock changes. Slots after the LSB are 0.
- R6: I2S (`cfg_fmt`=1): bit slot 0 of each channel is 0 and the MSB occupies slot 1, one bit later than left justified. Slots after the LSB are 0.
- R7: Right justified (`cfg_fmt`=2): the LSB occupies the last slot of the channel, and the leading unused slots are 0.
- R8: DSP (`cfg_fmt`=3): `lrck_o` is high only during bit slot 0 of the frame. The left MSB is in slot 0, the right word follows directly after the left LSB, and the remaining slots are 0.
- R9: In master mode `bclk_o` stays high and low for `cfg_div` system clocks each. A frame is 2×`cfg_slots` bit clocks long, and the first falling edge after reset starts a frame.
- R10: In slave mode (`cfg_master`=0), bit slot 0 of the left channel begins at the falling `bclk_i` edge where `lrck_i` falls (in DSP, where `lrck_i` is high). Data follows within four system clocks. `bclk_o` and `lrck_o` are held at 0.
- R11: `s_ready` is high exactly when the one-entry holding register is empty. An accepted pair is sent starting at the next frame start.
- R12: If the holding register is empty at a frame start, the previous pair is repeated and `underrun` is 1 for that whole frame. It is cleared at the next frame start that finds a pair waiting.
- R13: During reset `bclk_o`, `lrck_o`, `sdata`, `underrun` and `cfg_err` are 0 and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Framing: 0 left justified, 1 I2S, 2 right justified, 3 DSP |
| cfg_wlen | input | WLW (6) | Word length in bits, 16 to 32 |
| cfg_slots | input | SLW (6) | Bit clocks per channel slot |
| cfg_div | input | DIVW (8) | Bit clock half period in system clocks (master) |
| cfg_master | input | 1 | 1: generate clocks, 0: follow external clocks |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Holding register empty |
| s_left | input | SMPW (32) | Left sample |
| s_right | input | SMPW (32) | Right sample |
| bclk_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External frame clock (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| lrck_o | output | 1 | Generated frame clock (master) |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Current frame repeats the previous pair |
| cfg_err | output | 1 | Configuration rejected, data muted |

## Verification
The hardest case to reach is a frame start that falls on the same system clock edge as a handshake into an empty holding register. The design must then repeat the old pair and also keep the new one for the next frame. The stimulus withholds samples for a few frames and then turns the feed back on. It uses a divider of 1 and 2, so falling edges come often enough that handshakes land on frame starts. A slave run with an external bit clock much slower than the system clock checks the resynchronisation at frame clock edges. That run uses right justified data, where the slot position depends on the slot count.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [1:0] {
    FMT_LJ  = 2'd0,
    FMT_I2S = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_DSP = 2'd3
  } aud_fmt_e;
endpackage

// File: rtl/aud_bclk_div.sv
module aud_bclk_div #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [DIVW-1:0] div,
  output logic            bclk,
  output logic            fall_stb
);
  logic [DIVW-1:0] cnt_q;
  logic [DIVW-1:0] lim;
  logic            wrap;

  assign lim      = (div == '0) ? '0 : div - DIVW'(1);
  assign wrap     = cnt_q >= lim;
  assign fall_stb = en && wrap && bclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      bclk  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      bclk  <= ~bclk;
    end else begin
      cnt_q <= cnt_q + DIVW'(1);
    end
  end

  // R10: generator stays quiet when the block follows external clocks
  assert_bclk_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !bclk);
endmodule

// File: rtl/aud_clk_follow.sv
module aud_clk_follow (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic lrck_in,
  output logic fall_stb,
  output logic lrck_lvl
);
  logic b_s1, b_s2, b_d;
  logic l_s1, l_s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_s1 <= 1'b0; b_s2 <= 1'b0; b_d <= 1'b0;
      l_s1 <= 1'b0; l_s2 <= 1'b0;
    end else begin
      b_s1 <= bclk_in; b_s2 <= b_s1; b_d <= b_s2;
      l_s1 <= lrck_in; l_s2 <= l_s1;
    end
  end

  assign fall_stb = b_d & ~b_s2;
  assign lrck_lvl = l_s2;
endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift
  import aud_tx_pkg::*;
#(
  parameter int SMPW = 32,
  parameter int SLW  = 6,
  parameter int WLW  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  aud_fmt_e        fmt,
  input  logic [WLW-1:0]  wlen,
  input  logic [SLW-1:0]  slots,
  input  logic            mute,
  input  logic            slave,
  input  logic            fall_stb,
  input  logic            lrck_lvl,
  input  logic [SMPW-1:0] hold_l,
  input  logic [SMPW-1:0] hold_r,
  input  logic            hold_full,
  output logic            frame_load,
  output logic            sdata,
  output logic            lrck
);
  localparam int FW = SLW + 1;
  localparam int CW = ((SLW > WLW) ? SLW : WLW) + 2;
  localparam int IW = $clog2(SMPW);

  logic [FW-1:0]   slot_q, frame_last, next_slot;
  logic            lr_last_q;
  logic [SMPW-1:0] cur_l_q, cur_r_q, src_l, src_r, word;
  logic            is_dsp, left_start, right_start, in_right, bit_v, bit_d;
  logic [CW-1:0]   ns, s, w, j, idx;

  assign frame_last = {slots, 1'b0} - FW'(1);
  assign is_dsp     = (fmt == FMT_DSP);

  always_comb begin
    left_start  = slave && (is_dsp ? lrck_lvl : (!lrck_lvl && lr_last_q));
    right_start = slave && !is_dsp && lrck_lvl && !lr_last_q;
    if (left_start)              next_slot = '0;
    else if (right_start)        next_slot = FW'(slots);
    else if (slot_q >= frame_last) next_slot = '0;
    else                         next_slot = slot_q + FW'(1);
  end

  assign frame_load = fall_stb && (next_slot == '0);
  assign src_l = (frame_load && hold_full) ? hold_l : cur_l_q;
  assign src_r = (frame_load && hold_full) ? hold_r : cur_r_q;

  always_comb begin
    ns       = CW'(next_slot);
    s        = CW'(slots);
    w        = CW'(wlen);
    in_right = ns >= s;
    j        = in_right ? ns - s : ns;
    word     = in_right ? src_r : src_l;
    bit_v    = 1'b0;
    idx      = '0;
    case (fmt)
      FMT_LJ: begin
        bit_v = j < w;
        idx   = w - CW'(1) - j;
      end
      FMT_I2S: begin
        bit_v = (j != '0) && (j <= w);
        idx   = w - j;
      end
      FMT_RJ: begin
        bit_v = (j + w) >= s;
        idx   = s - CW'(1) - j;
      end
      default: begin
        if (ns < w) begin
          bit_v = 1'b1;
          word  = src_l;
          idx   = w - CW'(1) - ns;
        end else if (ns < (w << 1)) begin
          bit_v = 1'b1;
          word  = src_r;
          idx   = (w << 1) - CW'(1) - ns;
        end
      end
    endcase
    bit_d = bit_v ? word[idx[IW-1:0]] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q    <= frame_last;
      lr_last_q <= 1'b0;
      sdata     <= 1'b0;
      lrck      <= 1'b0;
      cur_l_q   <= '0;
      cur_r_q   <= '0;
    end else if (fall_stb) begin
      slot_q    <= next_slot;
      lr_last_q <= lrck_lvl;
      sdata     <= mute ? 1'b0 : bit_d;
      lrck      <= slave ? 1'b0 : (is_dsp ? (next_slot == '0) : (ns >= s));
      if (frame_load && hold_full) begin
        cur_l_q <= hold_l;
        cur_r_q <= hold_r;
      end
    end
  end

  // R4: data line moves only after a detected falling bit-clock edge
  assert_sdata_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $past(fall_stb));
  // R2: a rejected configuration keeps the line low
  assert_mute_R2: assert property (@(posedge clk) disable iff (rst)
    (mute && fall_stb) |=> !sdata);
endmodule

// File: rtl/aud_ser_tx.sv
module aud_ser_tx
  import aud_tx_pkg::*;
#(
  parameter int SMPW     = 32,
  parameter int MIN_WLEN = 16,
  parameter int SLW      = 6,
  parameter int DIVW     = 8,
  parameter int WLW      = $clog2(SMPW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      cfg_fmt,
  input  logic [WLW-1:0]  cfg_wlen,
  input  logic [SLW-1:0]  cfg_slots,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_master,
  input  logic            s_valid,
  output logic            s_ready,
  input  logic [SMPW-1:0] s_left,
  input  logic [SMPW-1:0] s_right,
  input  logic            bclk_i,
  input  logic            lrck_i,
  output logic            bclk_o,
  output logic            lrck_o,
  output logic            sdata,
  output logic            underrun,
  output logic            cfg_err
);
  localparam int CW = ((SLW > WLW) ? SLW : WLW) + 1;

  aud_fmt_e        fmt;
  logic            div_fall, fol_fall, fol_lrck, fall_stb, frame_load;
  logic            hold_full_q, err_d;
  logic [SMPW-1:0] hold_l_q, hold_r_q;

  assign fmt = aud_fmt_e'(cfg_fmt);

  aud_bclk_div #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst(rst), .en(cfg_master), .div(cfg_div),
    .bclk(bclk_o), .fall_stb(div_fall)
  );

  aud_clk_follow u_follow (
    .clk(clk), .rst(rst), .bclk_in(bclk_i), .lrck_in(lrck_i),
    .fall_stb(fol_fall), .lrck_lvl(fol_lrck)
  );

  assign fall_stb = cfg_master ? div_fall : fol_fall;

  aud_tx_shift #(.SMPW(SMPW), .SLW(SLW), .WLW(WLW)) u_shift (
    .clk(clk), .rst(rst), .fmt(fmt), .wlen(cfg_wlen), .slots(cfg_slots),
    .mute(cfg_err), .slave(!cfg_master), .fall_stb(fall_stb),
    .lrck_lvl(fol_lrck), .hold_l(hold_l_q), .hold_r(hold_r_q),
    .hold_full(hold_full_q), .frame_load(frame_load),
    .sdata(sdata), .lrck(lrck_o)
  );

  assign err_d = ((fmt == FMT_RJ) && (cfg_wlen == WLW'(SMPW)))
              || (cfg_wlen < WLW'(MIN_WLEN))
              || (cfg_wlen > WLW'(SMPW))
              || (CW'(cfg_slots) < CW'(cfg_wlen));

  assign s_ready = ~hold_full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full_q <= 1'b0;
      hold_l_q    <= '0;
      hold_r_q    <= '0;
      underrun    <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      cfg_err <= err_d;
      if (frame_load) underrun <= !hold_full_q;
      if (frame_load && hold_full_q) hold_full_q <= 1'b0;
      if (s_valid && !hold_full_q) begin
        hold_l_q    <= s_left;
        hold_r_q    <= s_right;
        hold_full_q <= 1'b1;
      end
    end
  end

  // R4: generated frame clock moves together with a falling bit clock
  assert_lrck_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && !$stable(lrck_o)) |-> $fell(bclk_o));
  // R12: an underrun only starts from an empty holding register
  assert_underrun_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> $past(!hold_full_q));
  // R2: the forbidden right-justified length is flagged
  assert_rj32_flag_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_fmt == 2'd2 && cfg_wlen == WLW'(SMPW)) |=> cfg_err);
  // R11: an accepted pair fills the holding register
  assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);
endmodule

// File: tb/aud_ser_tx_bench.sv
module aud_ser_tx_bench;
  localparam int HP = 8;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_fmt = 2'd0;
  logic [5:0] cfg_wlen = 6'd16;
  logic [5:0] cfg_slots = 6'd16;
  logic [7:0] cfg_div = 8'd2;
  logic cfg_master = 1'b1;
  logic s_valid = 1'b0;
  logic [31:0] s_left = '0, s_right = '0;
  logic bclk_i = 1'b0, lrck_i = 1'b0;
  logic s_ready, bclk_o, lrck_o, sdata, underrun, cfg_err;

  always #4 clk = ~clk;

  aud_ser_tx u_aud_ser_tx (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen),
    .cfg_slots(cfg_slots), .cfg_div(cfg_div), .cfg_master(cfg_master),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bclk_i(bclk_i), .lrck_i(lrck_i), .bclk_o(bclk_o), .lrck_o(lrck_o),
    .sdata(sdata), .underrun(underrun), .cfg_err(cfg_err)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  bit mon_en = 0, feed_en = 1;
  int m_fmt, m_w, m_s, m_div;
  bit m_master, m_err;
  logic [63:0] q[$];
  logic [31:0] cur_l, cur_r, pend_l, pend_r;
  bit pend, exp_und, prev_b, prev_sd, prev_lr, sl_started;
  int fall_cnt, last_rise, sl_cnt, sl_slot;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural bit position from the framing rules (R1, R5..R8)
  function automatic logic exp_bit(int slot);
    int j;
    logic [31:0] wd;
    if (m_err) return 1'b0;
    if (m_fmt == 3) begin
      if (slot < m_w) return cur_l[m_w-1-slot];
      if (slot < 2*m_w) return cur_r[2*m_w-1-slot];
      return 1'b0;
    end
    wd = (slot >= m_s) ? cur_r : cur_l;
    j = (slot >= m_s) ? slot - m_s : slot;
    if (m_fmt == 0 && j < m_w) return wd[m_w-1-j];
    if (m_fmt == 1 && j >= 1 && j <= m_w) return wd[m_w-j];
    if (m_fmt == 2 && j >= m_s - m_w) return wd[m_s-1-j];
    return 1'b0;
  endfunction

  function automatic logic exp_lr(int slot);
    return (m_fmt == 3) ? (slot == 0) : (slot >= m_s);
  endfunction

  function automatic string tag();
    if (m_err) return "R2";
    if (!m_master) return "R10";
    case (m_fmt)
      0: return "R1/R5";
      1: return "R1/R6";
      2: return "R1/R7";
      default: return "R1/R8";
    endcase
  endfunction

  task automatic frame_start();
    if (q.size() > 0) begin
      {cur_l, cur_r} = q.pop_front();
      exp_und = 0;
    end else exp_und = 1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > WD) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
    if (mon_en) begin
      if (m_master) begin
        automatic bit rise = !prev_b && bclk_o;
        automatic bit fall = prev_b && !bclk_o;
        if (fall) begin
          if (fall_cnt % (2*m_s) == 0) frame_start();
          fall_cnt++;
        end
        if (sdata !== prev_sd || lrck_o !== prev_lr) chk("R4", fall, 1);
        if (rise) begin
          if (last_rise >= 0) chk("R9", cyc - last_rise, 2*m_div);
          last_rise = cyc;
          if (fall_cnt > 0) begin
            automatic int sl = (fall_cnt - 1) % (2*m_s);
            chk(tag(), sdata, exp_bit(sl));
            chk((m_fmt == 3) ? "R8" : "R3", lrck_o, exp_lr(sl));
          end
        end
      end else begin
        sl_cnt++;
        if (sl_cnt == HP) begin
          sl_cnt = 0;
          if (!bclk_i) begin
            if (sl_started) chk(tag(), sdata, exp_bit(sl_slot));
            bclk_i = 1'b1;
          end else begin
            sl_slot = sl_started ? (sl_slot + 1) % (2*m_s) : 0;
            sl_started = 1;
            if (sl_slot == 0) frame_start();
            lrck_i = exp_lr(sl_slot);
            bclk_i = 1'b0;
          end
        end
        chk("R10", {bclk_o, lrck_o}, 0);
      end
      if (pend) q.push_back({pend_l, pend_r});
      if (m_master) begin
        chk("R11", s_ready, q.size() == 0);
        chk("R12", underrun, exp_und);
      end
      chk("R2", cfg_err, m_err);
      if (pend || !s_valid) begin
        if (feed_en) begin
          s_valid = 1'b1;
          s_left  = $urandom;
          s_right = $urandom;
        end else s_valid = 1'b0;
      end
      pend   = s_valid && s_ready;
      pend_l = s_left & ((m_w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << m_w) - 1));
      pend_r = s_right & ((m_w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << m_w) - 1));
      prev_b  = bclk_o;
      prev_sd = sdata;
      prev_lr = lrck_o;
    end
  end

  task automatic start(bit ma, int fmt, int w, int s, int dv, bit chk_rst);
    mon_en = 0;
    rst = 1'b1;
    m_master = ma; m_fmt = fmt; m_w = w; m_s = s; m_div = dv;
    m_err = (fmt == 2 && w == 32) || w < 16 || w > 32 || s < w;
    cfg_master = ma; cfg_fmt = 2'(fmt); cfg_wlen = 6'(w);
    cfg_slots = 6'(s); cfg_div = 8'(dv);
    s_valid = 1'b0; bclk_i = 1'b0; lrck_i = 1'b0; feed_en = 1;
    q.delete(); cur_l = '0; cur_r = '0; pend = 0; exp_und = 0;
    prev_b = 0; prev_sd = 0; prev_lr = 0; fall_cnt = 0; last_rise = -1;
    sl_cnt = 0; sl_slot = 0; sl_started = 0;
    repeat (3) @(negedge clk);
    if (chk_rst) begin
      chk("R13", bclk_o, 0); chk("R13", lrck_o, 0); chk("R13", sdata, 0);
      chk("R13", underrun, 0); chk("R13", cfg_err, 0); chk("R13", s_ready, 1);
    end
    @(negedge clk); #1;
    rst = 1'b0;
    mon_en = 1;
  endtask

  function automatic int mcyc(int frames);
    return frames * 2 * m_s * 2 * (m_master ? m_div : HP) + 8;
  endfunction

  initial begin
    start(1, 0, 16, 16, 2, 1); repeat (mcyc(6)) @(negedge clk);
    start(1, 1, 24, 32, 3, 0); repeat (mcyc(5)) @(negedge clk);
    start(1, 2, 20, 32, 2, 0); repeat (mcyc(5)) @(negedge clk);
    start(1, 3, 16, 16, 2, 0); repeat (mcyc(6)) @(negedge clk);
    start(1, 3, 24, 32, 1, 0); repeat (mcyc(5)) @(negedge clk);
    // R12: starve the holding register for several frames, then refill
    start(1, 0, 16, 16, 1, 0); repeat (mcyc(3)) @(negedge clk);
    #1 feed_en = 0; repeat (mcyc(3)) @(negedge clk);
    #1 feed_en = 1; repeat (mcyc(3)) @(negedge clk);
    start(1, 1, 18, 18, 2, 0);
    #1 feed_en = 0; repeat (mcyc(2)) @(negedge clk);
    #1 feed_en = 1; repeat (mcyc(2)) @(negedge clk);
    // R2: forbidden length in right justified mode
    start(1, 2, 32, 32, 1, 0); repeat (mcyc(5)) @(negedge clk);
    // R10: external clocks
    start(0, 1, 16, 16, 0, 0); repeat (mcyc(5)) @(negedge clk);
    start(0, 2, 24, 32, 0, 0); repeat (mcyc(4)) @(negedge clk);
    start(0, 3, 16, 20, 0, 0); repeat (mcyc(4)) @(negedge clk);
    start(0, 0, 32, 32, 0, 0); repeat (mcyc(3)) @(negedge clk);
    mon_en = 0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule